// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A single-clock synchronous memory whose 36-bit word is split into four 9-bit byte lanes. Every input is captured on the rising clock edge into an access register. The memory array is then written, or read into a pipelined output register, on the next edge. Either of two active-low start strobes opens a burst at the presented address, but only while the chip is enabled. After that, a 2-bit internal counter generates the next three addresses while the active-low step input is held low. A static order input picks whether the counter walks the low two address bits by increment or by XOR.

A write can cover any subset of the byte lanes through a lane-enable qualifier and per-lane strobes. A single global write input forces all four lanes. The tri-state data pins are replaced by a separate read-valid flag, which marks the cycles in which `rdata` holds the result of a read.

Top module: `burst_sram`

## Requirements
- R1: With `ce_n` low, a low level on either `host_start_n` or `ctl_start_n` at a rising edge starts a burst at `addr`, and that cycle's access uses `addr` itself.
- R2: `host_start_n` low while `ce_n` is high has no effect. With `ctl_start_n` high, an open burst simply continues, and with no open burst no access takes place.
- R3: `ctl_start_n` low while `ce_n` is high deselects: no access that cycle, and later cycles without a start perform no access.
- R4: With `order_sel` = 0, successive burst addresses take the low two bits as (start + n) mod 4, with the upper bits kept.
- R5: With `order_sel` = 1, the low two bits of burst address n are start XOR n.
- R6: A cycle inside a burst with `step_n` high repeats the previous burst address. With `step_n` low, the next one is used.
- R7: The burst counter is 2 bits wide, so the fifth address of a stepped burst equals the first.
- R8: A new start inside a burst restarts the counter at the new address.
- R9: With `all_wr_n` high and `lane_en_n` low, lane i (bits 9i+8..9i) is written only when `lane_wr_n[i]` is low. The other lanes keep their contents.
- R10: `all_wr_n` low writes all four lanes, whatever `lane_en_n` and `lane_wr_n` are.
- R11: With `all_wr_n` high, a cycle is a read when `lane_en_n` is high or all `lane_wr_n` bits are high.
- R12: Read data appears on `rdata` after the edge following the one that registered the read. A read registered right after a write to the same word returns the new data.
- R13: `rvalid` is low after reset (with `rdata` zero). It goes high one edge after a read is registered, and low one edge after a write, a deselect or an idle cycle is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| host_start_n | input | 1 | Burst start strobe, ignored while disabled |
| ctl_start_n | input | 1 | Burst start strobe, deselects while disabled |
| step_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 increment order, 1 XOR order |
| addr | input | ADDR_W | Word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| lane_en_n | input | 1 | Per-lane write qualifier, active low |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| all_wr_n | input | 1 | Global write, active low |
| rdata | output | 36 | Pipelined read data |
| rvalid | output | 1 | High when rdata carries a read result |

## Verification
On every cycle the assertions check several properties. The address in the access register matches the strobe address after a start. A held step keeps it unchanged. A global write produces a full lane mask. A disabled host strobe opens nothing. Two edges after a read, a deselect or a global write, `rvalid` has the expected level. The burst orders, the wrap after four words, the per-lane merge of partial writes and the read-after-write data can only be shown by the bench's scenarios. The bench sweeps every start address in both orders and every lane-strobe pattern against a word model of the array.

// File: rtl/sbram_pkg.sv
package sbram_pkg;

    localparam int unsigned LANES = 4;
    localparam int unsigned CNT_W = 2;

    typedef enum logic {
        ORD_INCR = 1'b0,
        ORD_XOR  = 1'b1
    } order_e;

    typedef struct packed {
        logic             valid;
        logic             write;
        logic [LANES-1:0] mask;
    } acc_ctl_t;

    function automatic logic [CNT_W-1:0] burst_offset(
        input logic [CNT_W-1:0] base,
        input logic [CNT_W-1:0] cnt,
        input order_e           ord
    );
        logic [CNT_W-1:0] r;
        if (ord == ORD_XOR) r = base ^ cnt;
        else                r = base + cnt;
        return r;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(
        input logic             all_n,
        input logic             en_n,
        input logic [LANES-1:0] wr_n
    );
        logic [LANES-1:0] m;
        if (!all_n)     m = '1;
        else if (!en_n) m = ~wr_n;
        else            m = '0;
        return m;
    endfunction

endpackage

// File: rtl/sbram_burst_seq.sv
module sbram_burst_seq
    import sbram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              host_start_n,
    input  logic              ctl_start_n,
    input  logic              step_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lane_en_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              all_wr_n,
    output acc_ctl_t          acc,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_data,
    output logic              burst_live
);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nx;
    logic [LANES-1:0]  mask;
    logic              start;
    logic              desel;

    assign start  = !ce_n && (!host_start_n || !ctl_start_n);
    assign desel  = ce_n && !ctl_start_n;
    assign cnt_nx = cnt_q + {{(CNT_W-1){1'b0}}, !step_n};
    assign mask   = lane_mask(all_wr_n, lane_en_n, lane_wr_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_live <= 1'b0;
            base_q     <= '0;
            cnt_q      <= '0;
            acc        <= '0;
            acc_addr   <= '0;
            acc_data   <= '0;
        end else begin
            acc_data <= wdata;
            if (start) begin
                burst_live <= 1'b1;
                base_q     <= addr;
                cnt_q      <= '0;
                acc        <= '{valid: 1'b1, write: |mask, mask: mask};
                acc_addr   <= addr;
            end else if (desel) begin
                burst_live <= 1'b0;
                acc        <= '0;
            end else if (burst_live) begin
                cnt_q    <= cnt_nx;
                acc      <= '{valid: 1'b1, write: |mask, mask: mask};
                acc_addr <= {base_q[ADDR_W-1:CNT_W],
                             burst_offset(base_q[CNT_W-1:0], cnt_nx, order_e'(order_sel))};
            end else begin
                acc <= '0;
            end
        end
    end

endmodule

// File: rtl/sbram_lanes.sv
module sbram_lanes
    import sbram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  acc_ctl_t                acc,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES*LANE_W-1:0] acc_data,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic do_read;
    assign do_read = acc.valid && !acc.write;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (acc.valid && acc.write && acc.mask[g])
                mem[acc_addr] <= acc_data[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst)          rd_q <= '0;
            else if (do_read) rd_q <= mem[acc_addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) rvalid <= 1'b0;
        else     rvalid <= do_read;
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import sbram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce_n,
    input  logic                    host_start_n,
    input  logic                    ctl_start_n,
    input  logic                    step_n,
    input  logic                    order_sel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    lane_en_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    all_wr_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int unsigned DATA_W = LANES * LANE_W;

    acc_ctl_t          acc;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_data;
    logic              burst_live;

    sbram_burst_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .ce_n         (ce_n),
        .host_start_n (host_start_n),
        .ctl_start_n  (ctl_start_n),
        .step_n       (step_n),
        .order_sel    (order_sel),
        .addr         (addr),
        .wdata        (wdata),
        .lane_en_n    (lane_en_n),
        .lane_wr_n    (lane_wr_n),
        .all_wr_n     (all_wr_n),
        .acc          (acc),
        .acc_addr     (acc_addr),
        .acc_data     (acc_data),
        .burst_live   (burst_live)
    );

    sbram_lanes #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lanes (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .acc_addr (acc_addr),
        .acc_data (acc_data),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

endmodule

// File: rtl/sbram_chk.sv
module sbram_chk
    import sbram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              host_start_n,
    input logic              ctl_start_n,
    input logic              step_n,
    input logic [ADDR_W-1:0] addr,
    input logic              lane_en_n,
    input logic [LANES-1:0]  lane_wr_n,
    input logic              all_wr_n,
    input logic              rvalid,
    input acc_ctl_t          acc,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              burst_live
);

    logic st, rd_req, ds;
    assign st     = !ce_n && (!host_start_n || !ctl_start_n);
    assign ds     = ce_n && !ctl_start_n;
    assign rd_req = all_wr_n && (lane_en_n || (&lane_wr_n));

    AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
        st |=> (acc.valid && acc_addr == $past(addr))); // R1

    AST_HOST_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ce_n && !host_start_n && ctl_start_n && !burst_live) |=> !acc.valid); // R2

    AST_DESEL_DROPS: assert property (@(posedge clk) disable iff (rst)
        ds |=> ##1 !rvalid); // R3

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!st && !ds && burst_live && step_n) |=> $stable(acc_addr)); // R6

    AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (rst)
        (st && !all_wr_n) |=> (acc.write && acc.mask == '1)); // R10

    AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
        (st && rd_req) |=> ##1 rvalid); // R12

    AST_WRITE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (st && !all_wr_n) |=> ##1 !rvalid); // R13

endmodule

bind burst_sram sbram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ce_n         (ce_n),
    .host_start_n (host_start_n),
    .ctl_start_n  (ctl_start_n),
    .step_n       (step_n),
    .addr         (addr),
    .lane_en_n    (lane_en_n),
    .lane_wr_n    (lane_wr_n),
    .all_wr_n     (all_wr_n),
    .rvalid       (rvalid),
    .acc          (acc),
    .acc_addr     (acc_addr),
    .burst_live   (burst_live)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;

    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, host_start_n = 1'b1, ctl_start_n = 1'b1, step_n = 1'b1;
    logic        order_sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [35:0] wdata = '0;
    logic        lane_en_n = 1'b1, all_wr_n = 1'b1;
    logic [3:0]  lane_wr_n = 4'hF;
    logic [35:0] rdata;
    logic        rvalid;

    int errors = 0;
    int checks = 0;
    string cur_req = "R13";

    // bench model of the array and access pipeline
    logic [35:0] mm [NW];
    logic        m_live = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]  m_cnt = '0;
    logic        m_v = 1'b0, m_w = 1'b0;
    logic [3:0]  m_mask = '0;
    logic [AW-1:0] m_a = '0;
    logic [35:0] m_d = '0;
    logic        exp_rv = 1'b0;
    logic [35:0] exp_rd = '0;

    always #2 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANE_W(9)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .host_start_n(host_start_n),
        .ctl_start_n(ctl_start_n), .step_n(step_n), .order_sel(order_sel),
        .addr(addr), .wdata(wdata), .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n),
        .all_wr_n(all_wr_n), .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [35:0] pat(input int a, input int s);
        logic [7:0] s8 = 8'(s);
        return {s8, 6'(a + s), 8'(a * 7 + s), ~6'(a), s8 ^ 8'h5A};
    endfunction

    task automatic check(input logic ok, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", cur_req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [3:0] mk;
        logic st, ds;
        if (m_v && m_w)
            for (int l = 0; l < 4; l++)
                if (m_mask[l]) mm[m_a][l*9 +: 9] = m_d[l*9 +: 9];
        exp_rv = m_v && !m_w;
        if (exp_rv) exp_rd = mm[m_a];
        mk = !all_wr_n ? 4'hF : (!lane_en_n ? ~lane_wr_n : 4'h0);
        st = !ce_n && (!host_start_n || !ctl_start_n);
        ds = ce_n && !ctl_start_n;
        m_d = wdata;
        if (st) begin
            m_live = 1'b1; m_base = addr; m_cnt = 2'd0;
            m_v = 1'b1; m_w = |mk; m_mask = mk; m_a = addr;
        end else if (ds) begin
            m_live = 1'b0; m_v = 1'b0;
        end else if (m_live) begin
            m_cnt = m_cnt + 2'(!step_n);
            m_v = 1'b1; m_w = |mk; m_mask = mk;
            m_a = {m_base[AW-1:2], order_sel ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
        end else begin
            m_v = 1'b0;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(rvalid === exp_rv, {35'd0, rvalid}, {35'd0, exp_rv});
        if (exp_rv) check(rdata === exp_rd, rdata, exp_rd);
    endtask

    task automatic cyc(input logic ce, input logic hs, input logic cs, input logic st,
                       input int a, input logic aw, input logic le,
                       input logic [3:0] lw, input logic [35:0] d);
        ce_n = ce; host_start_n = hs; ctl_start_n = cs; step_n = st;
        addr = AW'(a); all_wr_n = aw; lane_en_n = le; lane_wr_n = lw; wdata = d;
        tick();
    endtask

    task automatic rd_start(input int a, input logic use_host);
        cyc(1'b0, !use_host, use_host, 1'b1, a, 1'b1, 1'b1, 4'hF, '0);
    endtask
    task automatic rd_cont(input logic st);
        cyc(1'b0, 1'b1, 1'b1, st, 0, 1'b1, 1'b1, 4'hF, '0);
    endtask
    task automatic desel();
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b1, 1'b1, 4'hF, '0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R13 reset state
        cur_req = "R13";
        check(rvalid === 1'b0, {35'd0, rvalid}, 36'd0);
        check(rdata === 36'd0, rdata, 36'd0);

        // fill: global writes in stepped increment bursts (R10, R4)
        cur_req = "R10";
        order_sel = 1'b0;
        for (int b = 0; b < NW; b += 4) begin
            cyc(1'b0, b[2], !b[2], 1'b1, b, 1'b0, 1'b1, 4'hF, pat(b, 1));
            for (int k = 1; k < 4; k++)
                cyc(1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b1, 4'hF, pat(b + k, 1));
        end
        cur_req = "R3";
        desel();
        desel();

        // every start address, both orders, five stepped words (R4, R5, R7)
        for (int o = 0; o < 2; o++) begin
            order_sel = o[0];
            for (int a = 0; a < NW; a++) begin
                cur_req = o ? "R5" : "R4";
                rd_start(a, a[0]);
                for (int k = 0; k < 3; k++) rd_cont(1'b0);
                cur_req = "R7";
                rd_cont(1'b0);
            end
            cur_req = "R3";
            desel();
            rd_cont(1'b0);
        end

        // step held (R6)
        cur_req = "R6";
        order_sel = 1'b0;
        rd_start(9, 1'b1);
        rd_cont(1'b1); rd_cont(1'b1); rd_cont(1'b0); rd_cont(1'b1); rd_cont(1'b0);

        // restart inside a burst (R8)
        cur_req = "R8";
        rd_start(20, 1'b1);
        rd_cont(1'b0);
        rd_start(41, 1'b0);
        rd_cont(1'b0); rd_cont(1'b0);

        // host strobe while disabled (R2)
        cur_req = "R2";
        rd_start(33, 1'b1);
        rd_cont(1'b0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 60, 1'b1, 1'b1, 4'hF, '0);
        rd_cont(1'b0);
        desel();
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 60, 1'b1, 1'b1, 4'hF, '0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 61, 1'b1, 1'b1, 4'hF, '0);
        rd_cont(1'b0);

        // lane strobe patterns (R9, R11)
        for (int m = 0; m < 16; m++) begin
            for (int e = 0; e < 2; e++) begin
                cur_req = (e == 0 && m != 0) ? "R9" : "R11";
                cyc(1'b0, 1'b0, 1'b1, 1'b1, 50, 1'b1, e[0], ~4'(m), pat(m * 2 + e, 100));
                rd_start(50, 1'b1);
            end
        end

        // global write overrides lane controls (R10)
        cur_req = "R10";
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 51, 1'b0, 1'b1, 4'hF, pat(51, 7));
        rd_start(51, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 52, 1'b0, 1'b0, 4'hE, pat(52, 9));
        rd_start(52, 1'b1);

        // read right after write to same word (R12)
        cur_req = "R12";
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 12, 1'b1, 1'b0, 4'h0, pat(12, 33));
        rd_start(12, 1'b1);
        rd_cont(1'b1);

        // write inside a read burst drops rvalid (R13)
        cur_req = "R13";
        rd_start(28, 1'b1);
        rd_cont(1'b0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b1, 4'hF, pat(30, 44));
        rd_cont(1'b0);
        desel();
        desel();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule